// File: doc/BRIEF.md
# Clock Domain Source-Select Divider

This block produces the clock of one clock domain. It chooses one of five incoming clocks: a low-speed 32.768 kHz oscillator, the 26 MHz main oscillator, or one of three PLL outputs. It then either passes the chosen clock straight through or divides it by an integer ratio. Each divided period has a high phase (the wait count) and a low phase (the hold count), so the duty cycle is set directly and is not implied by the ratio alone.

Software controls the block through one 32-bit configuration word on a simple synchronous write/read port. A change of source runs a glitch-free handshake: the old clock is first turned off at its low phase, and only then is the new clock turned on. New phase counts take effect only when software asks for them. The divider applies them at the end of a whole output period. Two status bits clear by themselves when a switch or an update has completed. A gate, driven both from the configuration word and from a dedicated input, forces the output low without clipping a pulse.

Two build-time variants exist. A narrow variant has 3-bit phase counts, which limits the ratio to 16. A fixed variant is tied to the third PLL (code 4) and ignores writes to the select field.

Top module: `clkdom_gen`

## Requirements
- R1: After reset the configuration word reads 0x01000101: source code 1, domain gate bit (bit 8) set, bypass (bit 24) set, both counts 0, both status bits (3 and 25) clear. The output then follows the main oscillator.
- R2: Bits [2:0] select the source: 0 low-speed oscillator, 1 main oscillator, 2/3/4 the three PLLs. A write with a code above 4 leaves the field unchanged and starts no switch.
- R3: After a write that changes bits [2:0], bit 3 reads 1 until the output runs from the newly selected source, then reads 0. Two sources are never enabled onto the output at the same time.
- R4: A write to bits [2:0] while bit 3 reads 1 is ignored.
- R5: With bypass clear, one output period is wait+hold+2 cycles of the selected source, high for wait+1 and low for hold+1. Wait sits in bits [19:16] and hold in bits [23:20], so ratios 2 to 32 are available.
- R6: With bit 24 set, the output equals the selected source clock.
- R7: Writing the counts with bit 25 clear stores them but leaves the output period unchanged. Writing bit 25 as 1 requests their use; bit 25 then reads 1 until the divider runs with them, and clears by itself.
- R8: While bit 25 reads 1, writes to the count fields are ignored.
- R9: New counts are loaded only at the end of a complete output period, so every observed period has either the old length and duty or the new ones.
- R10: Driving gate_en low, or clearing bit 8, holds the output low. Restoring both brings back whole periods.
- R11: In the narrow variant (PHASE_W=3) bits 19 and 23 read 0, and counts of 7/7 give a period of 16.
- R12: In the fixed variant bits [2:0] always read 4, writes to them are ignored, and the output comes from source 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration port clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Registered read-back of configuration and status |
| src_clk | input | NUM_SRC | Candidate source clocks, index = select code |
| gate_en | input | 1 | External domain gate, low forces the output low |
| clk_out | output | 1 | Domain clock output |

## Verification
Checked on every configuration-clock cycle: the select field never holds an illegal code; at most one source enable is active at any moment; the select field does not move while a switch is busy; the count fields do not move while an update is pending. The variant-specific field rules are also checked in each cycle. Only the bench scenarios can show the output waveform itself. Those scenarios cover the measured period and high time for every wait/hold pair of both widths, the absence of mixed-length periods across an update, the pass-through in bypass, the output held low by the gate, and switches between sources with very different speeds.

// File: rtl/clkdom_pkg.sv
`timescale 1ns/1ps
package clkdom_pkg;
  localparam int CFG_W    = 32;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 3;
  localparam int BUSY_BIT = 3;
  localparam int GATE_BIT = 8;
  localparam int WAIT_LSB = 16;
  localparam int HOLD_LSB = 20;
  localparam int FIELD_W  = 4;
  localparam int BYP_BIT  = 24;
  localparam int UPD_BIT  = 25;

  typedef enum logic [SEL_W-1:0] {
    SRC_SLOW  = 3'd0,
    SRC_MAIN  = 3'd1,
    SRC_PLL_A = 3'd2,
    SRC_PLL_B = 3'd3,
    SRC_PLL_C = 3'd4
  } src_code_e;
endpackage

// File: rtl/clkdom_regs.sv
`timescale 1ns/1ps
module clkdom_regs
  import clkdom_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int PHASE_W    = 4,
  parameter bit FIXED_SRC  = 1'b0,
  parameter int FIXED_CODE = 4,
  parameter int RESET_SRC  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               ack_tgl,
  input  logic               gate_en,
  output logic [NUM_SRC-1:0] sel_oh,
  output logic [PHASE_W-1:0] wait_q,
  output logic [PHASE_W-1:0] hold_q,
  output logic               bypass_q,
  output logic               gate_run,
  output logic               req_tgl,
  output logic [CFG_W-1:0]   rd_data
);
  localparam int START_SEL = FIXED_SRC ? FIXED_CODE : RESET_SRC;
  localparam logic [NUM_SRC-1:0] START_OH = NUM_SRC'(1) << START_SEL;

  logic [SEL_W-1:0]   sel_q;
  logic               gate_bit_q;
  logic [NUM_SRC-1:0] en_s1, en_s2;
  logic [1:0]         ack_p;
  logic               busy, pending, sel_legal;
  logic [CFG_W-1:0]   rd_nx;
  logic               unused_wr;

  assign unused_wr = ^wr_data;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_oh
    assign sel_oh[g] = (32'(sel_q) == g);
  end

  // Source enables and the update acknowledge arrive from other clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_s1 <= START_OH;
      en_s2 <= START_OH;
      ack_p <= 2'b00;
    end else begin
      en_s1 <= src_en;
      en_s2 <= en_s1;
      ack_p <= {ack_p[0], ack_tgl};
    end
  end

  assign busy      = (en_s2 != sel_oh);
  assign pending   = req_tgl ^ ack_p[1];
  assign sel_legal = (32'(wr_data[SEL_LSB +: SEL_W]) < NUM_SRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= SEL_W'(START_SEL);
      gate_bit_q <= 1'b1;
      bypass_q   <= 1'b1;
      wait_q     <= '0;
      hold_q     <= '0;
      req_tgl    <= 1'b0;
    end else if (wr_en) begin
      if (!FIXED_SRC && !busy && sel_legal)
        sel_q <= wr_data[SEL_LSB +: SEL_W];
      gate_bit_q <= wr_data[GATE_BIT];
      bypass_q   <= wr_data[BYP_BIT];
      if (!pending) begin
        wait_q <= wr_data[WAIT_LSB +: PHASE_W];
        hold_q <= wr_data[HOLD_LSB +: PHASE_W];
        if (wr_data[UPD_BIT])
          req_tgl <= ~req_tgl;
      end
    end
  end

  assign gate_run = gate_bit_q & gate_en;

  always_comb begin
    rd_nx = '0;
    rd_nx[SEL_LSB +: SEL_W]    = sel_q;
    rd_nx[BUSY_BIT]            = busy;
    rd_nx[GATE_BIT]            = gate_bit_q;
    rd_nx[WAIT_LSB +: PHASE_W] = wait_q;
    rd_nx[HOLD_LSB +: PHASE_W] = hold_q;
    rd_nx[BYP_BIT]             = bypass_q;
    rd_nx[UPD_BIT]             = pending;
  end

  always_ff @(posedge clk) rd_data <= rd_nx;
endmodule

// File: rtl/clkdom_srcmux.sv
`timescale 1ns/1ps
module clkdom_srcmux #(
  parameter int NUM_SRC   = 5,
  parameter int RESET_SRC = 1
) (
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [NUM_SRC-1:0] sel_oh,
  output logic [NUM_SRC-1:0] src_en,
  output logic               mclk
);
  logic [NUM_SRC-1:0] others_on;
  logic [NUM_SRC-1:0] want;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
    logic st1, st2;
    assign others_on[g] = |(src_en & ~(NUM_SRC'(1) << g));
    assign want[g]      = sel_oh[g] & ~others_on[g];
    // Enable flops move on the falling edge, while their clock is low.
    always_ff @(negedge src_clk[g]) begin
      if (rst) begin
        st1 <= (RESET_SRC == g);
        st2 <= (RESET_SRC == g);
      end else begin
        st1 <= want[g];
        st2 <= st1;
      end
    end
    assign src_en[g] = st2;
  end

  assign mclk = |(src_clk & src_en);
endmodule

// File: rtl/clkdom_div.sv
`timescale 1ns/1ps
module clkdom_div #(
  parameter int PHASE_W = 4
) (
  input  logic               mclk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] wait_in,
  input  logic [PHASE_W-1:0] hold_in,
  input  logic               req_tgl,
  input  logic               bypass_in,
  input  logic               gate_in,
  output logic               ack_tgl,
  output logic               clk_out
);
  localparam int CW = PHASE_W + 1;

  logic [1:0]         rst_p;
  logic               rst_m;
  logic [1:0]         req_p, byp_p, gate_p;
  logic [CW-1:0]      cnt, cnt_nx;
  logic [PHASE_W-1:0] act_w, act_h;
  logic               gate_d, div_q, last;

  always_ff @(posedge mclk) rst_p <= {rst_p[0], rst};
  assign rst_m = rst_p[1];

  always_ff @(negedge mclk) begin
    if (rst_m) begin
      byp_p  <= 2'b11;
      gate_p <= 2'b11;
    end else begin
      byp_p  <= {byp_p[0], bypass_in};
      gate_p <= {gate_p[0], gate_in};
    end
  end

  assign cnt_nx = cnt + CW'(1);
  assign last   = (cnt == CW'(act_w) + CW'(act_h) + CW'(1));

  always_ff @(posedge mclk) begin
    if (rst_m) begin
      req_p   <= 2'b00;
      cnt     <= '0;
      act_w   <= '0;
      act_h   <= '0;
      ack_tgl <= 1'b0;
      gate_d  <= 1'b1;
      div_q   <= 1'b0;
    end else begin
      req_p <= {req_p[0], req_tgl};
      if (last) begin
        cnt    <= '0;
        gate_d <= gate_p[1];
        div_q  <= gate_p[1];
        if (req_p[1] != ack_tgl) begin
          act_w   <= wait_in;
          act_h   <= hold_in;
          ack_tgl <= req_p[1];
        end
      end else begin
        cnt   <= cnt_nx;
        div_q <= gate_d & (cnt_nx <= CW'(act_w));
      end
    end
  end

  assign clk_out = byp_p[1] ? (mclk & gate_p[1]) : div_q;
endmodule

// File: rtl/clkdom_gen.sv
`timescale 1ns/1ps
module clkdom_gen
  import clkdom_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int PHASE_W    = 4,
  parameter bit FIXED_SRC  = 1'b0,
  parameter int FIXED_CODE = 4,
  parameter int RESET_SRC  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  output logic [CFG_W-1:0]   rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               gate_en,
  output logic               clk_out
);
  localparam int START_SEL = FIXED_SRC ? FIXED_CODE : RESET_SRC;

  logic [NUM_SRC-1:0] sel_oh, src_en;
  logic [PHASE_W-1:0] wait_q, hold_q;
  logic               bypass_q, gate_run, req_tgl, ack_tgl, mclk;

  clkdom_regs #(
    .NUM_SRC(NUM_SRC), .PHASE_W(PHASE_W), .FIXED_SRC(FIXED_SRC),
    .FIXED_CODE(FIXED_CODE), .RESET_SRC(RESET_SRC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .src_en(src_en), .ack_tgl(ack_tgl), .gate_en(gate_en),
    .sel_oh(sel_oh), .wait_q(wait_q), .hold_q(hold_q),
    .bypass_q(bypass_q), .gate_run(gate_run), .req_tgl(req_tgl),
    .rd_data(rd_data)
  );

  clkdom_srcmux #(.NUM_SRC(NUM_SRC), .RESET_SRC(START_SEL)) u_mux (
    .rst(rst), .src_clk(src_clk), .sel_oh(sel_oh),
    .src_en(src_en), .mclk(mclk)
  );

  clkdom_div #(.PHASE_W(PHASE_W)) u_div (
    .mclk(mclk), .rst(rst), .wait_in(wait_q), .hold_in(hold_q),
    .req_tgl(req_tgl), .bypass_in(bypass_q), .gate_in(gate_run),
    .ack_tgl(ack_tgl), .clk_out(clk_out)
  );
endmodule

// File: rtl/clkdom_gen_chk.sv
`timescale 1ns/1ps
module clkdom_gen_chk
  import clkdom_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int PHASE_W    = 4,
  parameter bit FIXED_SRC  = 1'b0,
  parameter int FIXED_CODE = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [CFG_W-1:0]   rd_data,
  input logic [NUM_SRC-1:0] src_en
);
  p_sel_legal_r2: assert property (@(posedge clk) disable iff (rst)
    32'(rd_data[SEL_LSB +: SEL_W]) < NUM_SRC);

  p_one_source_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en));

  p_busy_holds_sel_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_data[BUSY_BIT]) && rd_data[BUSY_BIT]) |-> $stable(rd_data[SEL_LSB +: SEL_W]));

  p_pending_holds_counts_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_data[UPD_BIT]) && rd_data[UPD_BIT]) |-> $stable(rd_data[HOLD_LSB+FIELD_W-1:WAIT_LSB]));

  if (PHASE_W < FIELD_W) begin : g_narrow
    p_narrow_fields_r11: assert property (@(posedge clk) disable iff (rst)
      (rd_data[WAIT_LSB+PHASE_W +: FIELD_W-PHASE_W] == '0) &&
      (rd_data[HOLD_LSB+PHASE_W +: FIELD_W-PHASE_W] == '0));
  end

  if (FIXED_SRC) begin : g_fixed
    p_fixed_sel_r12: assert property (@(posedge clk) disable iff (rst)
      (32'(rd_data[SEL_LSB +: SEL_W]) == FIXED_CODE) && !rd_data[BUSY_BIT]);
  end
endmodule

bind clkdom_gen clkdom_gen_chk #(
  .NUM_SRC(NUM_SRC), .PHASE_W(PHASE_W), .FIXED_SRC(FIXED_SRC), .FIXED_CODE(FIXED_CODE)
) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .src_en(src_en)
);

// File: tb/tb_clkdom_gen.sv
`timescale 1ns/1ps
module tb_clkdom_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  wr_en = '0;
  logic [31:0] wr_data = '0;
  logic        s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0;
  logic [4:0]  src;
  logic        gate_en = 1'b1;
  logic [31:0] rd0, rd1, rd2;
  logic        out0, out1, out2;
  int          n_chk = 0, n_fail = 0;
  int          mon_sel = 1, mon_dut = 0;
  logic        mon_src, mon_out;
  int          seq_per[16], seq_hi[16];

  always #10  clk = ~clk;
  always #100 s0 = ~s0;
  always #19  s1 = ~s1;
  always #5   s2 = ~s2;
  always #7   s3 = ~s3;
  always #4   s4 = ~s4;
  assign src = {s4, s3, s2, s1, s0};

  assign mon_src = src[mon_sel];
  assign mon_out = (mon_dut == 0) ? out0 : (mon_dut == 1) ? out1 : out2;

  clkdom_gen dut (.clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_data(wr_data),
    .rd_data(rd0), .src_clk(src), .gate_en(gate_en), .clk_out(out0));
  clkdom_gen #(.PHASE_W(3)) dut_nar (.clk(clk), .rst(rst), .wr_en(wr_en[1]),
    .wr_data(wr_data), .rd_data(rd1), .src_clk(src), .gate_en(gate_en), .clk_out(out1));
  clkdom_gen #(.FIXED_SRC(1'b1)) dut_fix (.clk(clk), .rst(rst), .wr_en(wr_en[2]),
    .wr_data(wr_data), .rd_data(rd2), .src_clk(src), .gate_en(gate_en), .clk_out(out2));

  function automatic logic [31:0] cw(input int sel, input bit gate, input bit byp,
                                     input bit upd, input int w, input int h);
    logic [31:0] v;
    v = '0;
    v[2:0]   = 3'(sel);
    v[8]     = gate;
    v[19:16] = 4'(w);
    v[23:20] = 4'(h);
    v[24]    = byp;
    v[25]    = upd;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en[idx] = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en[idx] = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(posedge clk);
    #1;
    d = (idx == 0) ? rd0 : (idx == 1) ? rd1 : rd2;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_idle(input int idx, input string req);
    logic [31:0] d;
    int g;
    g = 0;
    rd(idx, d);
    while ((d[3] | d[25]) && g < 3000) begin
      rd(idx, d);
      g++;
    end
    chk(!(d[3] | d[25]), req, "status bits 25/3 clear", {d[25], d[3]}, 0);
  endtask

  task automatic samp(output logic v);
    @(posedge mon_src);
    #1;
    v = mon_out;
  endtask

  // Measure n back-to-back periods in cycles of the monitored source.
  task automatic meas(input int n);
    logic p, c;
    int g, per, hi, k;
    for (int i = 0; i < 16; i++) begin
      seq_per[i] = 0;
      seq_hi[i]  = 0;
    end
    samp(p);
    g = 0;
    while (g < 400) begin
      samp(c);
      g++;
      if (!p && c) break;
      p = c;
    end
    if (g >= 400) return;
    per = 1; hi = 1; p = 1'b1; k = 0;
    while (k < n && g < 4000) begin
      samp(c);
      g++;
      if (!p && c) begin
        seq_per[k] = per;
        seq_hi[k]  = hi;
        k++;
        per = 1;
        hi  = 1;
      end else begin
        per++;
        if (c) hi++;
      end
      p = c;
    end
  endtask

  task automatic check_div(input string req, input int w, input int h);
    meas(1);
    chk(seq_per[0] == w + h + 2, req, "period", seq_per[0], w + h + 2);
    chk(seq_hi[0] == w + 1, req, "high phase", seq_hi[0], w + 1);
  endtask

  task automatic check_bypass(input string req);
    int bad;
    bad = 0;
    repeat (6) begin
      @(posedge mon_src); #1;
      if (mon_out !== 1'b1) bad++;
      @(negedge mon_src); #1;
      if (mon_out !== 1'b0) bad++;
    end
    chk(bad == 0, req, "output follows source (mismatches)", bad, 0);
  endtask

  task automatic check_low(input string req);
    int hits;
    hits = 0;
    repeat (60) begin
      @(posedge mon_src); #1;
      if (mon_out !== 1'b0) hits++;
    end
    chk(hits == 0, req, "output held low (high samples)", hits, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual time %0t expected completion earlier", $time);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle(4);

    // R1: reset state of all three variants
    rd(0, d); chk(d == 32'h0100_0101, "R1", "reset word", d, 32'h0100_0101);
    rd(1, d); chk(d == 32'h0100_0101, "R1", "reset word narrow", d, 32'h0100_0101);
    rd(2, d); chk(d == 32'h0100_0104, "R12", "reset word fixed", d, 32'h0100_0104);
    mon_dut = 0; mon_sel = 1;
    check_bypass("R1");

    // R2: illegal code is dropped
    wr(0, cw(6, 1, 1, 0, 0, 0));
    rd(0, d); chk(d[3:0] == 4'h1, "R2", "select/busy after code 6", d[3:0], 1);
    wr(0, cw(5, 1, 1, 0, 0, 0));
    rd(0, d); chk(d[3:0] == 4'h1, "R2", "select/busy after code 5", d[3:0], 1);

    // R3 / R4: switch to source 4, second write while busy is dropped
    wr(0, cw(4, 1, 1, 0, 0, 0));
    rd(0, d); chk(d[3:0] == 4'hC, "R3", "busy set with new code", d[3:0], 12);
    wr(0, cw(2, 1, 1, 0, 0, 0));
    wait_idle(0, "R3");
    rd(0, d); chk(d[2:0] == 3'd4, "R4", "select kept during busy", d[2:0], 4);
    mon_sel = 4;
    settle(4);
    check_bypass("R6");

    // R7: counts without request do not act
    wr(0, cw(4, 1, 0, 0, 3, 5));
    settle(10);
    rd(0, d); chk(d[25:16] == 10'h053, "R7", "stored counts, no pending", d[25:16], 10'h053);
    check_div("R7", 0, 0);
    wr(0, cw(4, 1, 0, 1, 3, 5));
    rd(0, d); chk(d[25] == 1'b1, "R7", "pending bit after request", d[25], 1);
    wait_idle(0, "R7");
    check_div("R5", 3, 5);

    // R8: second request while pending is dropped
    wr(0, cw(4, 1, 0, 1, 1, 1));
    wr(0, cw(4, 1, 0, 1, 7, 7));
    wait_idle(0, "R8");
    rd(0, d); chk(d[23:16] == 8'h11, "R8", "counts kept while pending", d[23:16], 8'h11);
    check_div("R8", 1, 1);

    // R9: no mixed period across an update
    wr(0, cw(4, 1, 0, 1, 6, 9));
    meas(10);
    ok = 1'b1;
    for (int i = 0; i < 10; i++)
      if (!((seq_per[i] == 4 && seq_hi[i] == 2) || (seq_per[i] == 17 && seq_hi[i] == 7)))
        ok = 1'b0;
    chk(ok, "R9", "all periods old or new (first seen)", seq_per[0], 4);
    chk(seq_per[9] == 17 && seq_hi[9] == 7, "R9", "final period", seq_per[9], 17);
    wait_idle(0, "R9");

    // R5: every wait/hold pair
    for (int w = 0; w < 16; w++) begin
      for (int h = 0; h < 16; h++) begin
        wr(0, cw(4, 1, 0, 1, w, h));
        wait_idle(0, "R5");
        check_div("R5", w, h);
      end
    end

    // R3: divider on other sources after switches
    wr(0, cw(4, 1, 0, 1, 2, 1));
    wait_idle(0, "R5");
    wr(0, cw(2, 1, 0, 0, 2, 1));
    wait_idle(0, "R3");
    mon_sel = 2;
    check_div("R3", 2, 1);
    wr(0, cw(0, 1, 0, 0, 2, 1));
    wait_idle(0, "R3");
    rd(0, d); chk(d[2:0] == 3'd0, "R3", "select low-speed", d[2:0], 0);
    mon_sel = 0;
    check_div("R3", 2, 1);
    wr(0, cw(4, 1, 0, 1, 1, 2));
    wait_idle(0, "R3");
    mon_sel = 4;
    check_div("R3", 1, 2);

    // R10: gating by input and by bit 8
    gate_en = 1'b0;
    settle(20);
    check_low("R10");
    gate_en = 1'b1;
    settle(10);
    check_div("R10", 1, 2);
    wr(0, cw(4, 0, 0, 0, 1, 2));
    settle(20);
    check_low("R10");
    wr(0, cw(4, 0, 1, 0, 1, 2));
    settle(20);
    check_low("R10");
    wr(0, cw(4, 1, 0, 0, 1, 2));
    settle(10);
    check_div("R10", 1, 2);

    // R11: narrow variant
    mon_dut = 1;
    wr(1, cw(4, 1, 1, 0, 0, 0));
    wait_idle(1, "R11");
    wr(1, cw(4, 1, 0, 1, 15, 15));
    wait_idle(1, "R11");
    rd(1, d); chk(d[23:16] == 8'h77, "R11", "narrow fields", d[23:16], 8'h77);
    check_div("R11", 7, 7);
    for (int w = 0; w < 8; w++) begin
      for (int h = 0; h < 8; h++) begin
        wr(1, cw(4, 1, 0, 1, w, h));
        wait_idle(1, "R11");
        check_div("R11", w, h);
      end
    end

    // R12: fixed variant
    mon_dut = 2;
    wr(2, cw(2, 1, 1, 0, 0, 0));
    rd(2, d); chk(d[3:0] == 4'h4, "R12", "fixed select after write", d[3:0], 4);
    settle(10);
    check_bypass("R12");

    summary();
    $finish;
  end
endmodule